// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of an interval timer. A free-running system clock drives it, and a single-cycle `tick_i` enable advances it. A load strobe captures a 16-bit reload value together with an operating mode, and the channel starts counting from that value. It keeps one down-counter, and the visible count and the output bit both follow from that counter.

The channel supports six modes. Two of them are one-shot forms: one raises the output at terminal count, the other drops it there. There is a periodic rate pulse, a square wave, and two single-tick strobes. `gate_i` acts in one of two ways depending on the mode. In some modes its level pauses counting. In the others its rising edge restarts the period from the reload value.

Top module: `interval_chan`

## Requirements
- R1: After reset, `count_o` is 0, `out_o` is 0, the mode is 0 and the period is 65536.
- R2: A load strobe updates the outputs at the following clock edge. `count_o` becomes `reload_i`, a reload of 0 stands for a period of 65536, and elapsed ticks restart from zero. `out_o` takes the initial level of the new mode: 1 in modes 1 and 3, 0 in the others. A load wins over a gate restart and over a tick in the same cycle.
- R3: Mode 0 (raise at terminal count): `out_o` is 0 until the elapsed ticks reach the period. It then goes to 1 and stays at 1 until the next load.
- R4: Mode 1 (one-shot low at terminal count): `out_o` is 1 while the elapsed ticks are below the period, and 0 after that.
- R5: Mode 2 (rate): `count_o` equals period − (elapsed mod period). `out_o` is 1 exactly when elapsed is non-zero and a multiple of the period.
- R6: Mode 3 (square wave): `count_o` equals period − ((2·elapsed) mod period). `out_o` is 1 while (elapsed mod period) < (period+1)/2, and 0 otherwise.
- R7: Modes 4 (software strobe) and 5 (hardware strobe): `out_o` is 1 only while elapsed equals the period. It is therefore a single counted tick wide.
- R8: In modes 1, 2, 3 and 5, a rising edge of `gate_i` restarts the elapsed count at zero. An edge is `gate_i` high in a cycle after it was sampled low in the previous cycle. Without such an edge, a tick, or a load, the outputs hold.
- R9: In modes 0 and 4, `tick_i` is ignored while `gate_i` is low. The count and the output hold.
- R10: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R11: In modes 0, 1, 4 and 5, `count_o` is (period − elapsed) truncated to 16 bits, so it wraps through 0xFFFF after terminal count and keeps counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one system cycle per counted tick |
| gate_i | input | 1 | Gate: level enable or edge restart, depending on the mode |
| load_i | input | 1 | Load strobe for the reload value and the mode |
| reload_i | input | 16 | Reload value, 0 meaning 65536 |
| mode_i | input | 3 | Mode code sampled with the load strobe |
| out_o | output | 1 | Channel output |
| count_o | output | 16 | Visible count |

## Verification
Every result is due one clock edge after its cause. A tick, a gate edge or a load sampled at a rising edge appears on `count_o` and `out_o` right after that same edge. The bench drives its inputs on the falling edge. At each rising edge it advances a behavioural model that tracks elapsed ticks as an integer, and it compares both outputs with the mode formulas at the next falling edge, half a period later. Tick patterns alternate between dense and sparse, so that suspension and holding can be seen between counted ticks.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

  typedef enum logic [2:0] {
    MD_TC_RISE   = 3'd0,
    MD_ONE_SHOT  = 3'd1,
    MD_RATE      = 3'd2,
    MD_SQUARE    = 3'd3,
    MD_SW_STROBE = 3'd4,
    MD_HW_STROBE = 3'd5
  } mode_e;

  // codes 6 and 7 fold onto the periodic modes
  function automatic mode_e norm_mode(input logic [2:0] raw);
    case (raw)
      3'd6:    return MD_RATE;
      3'd7:    return MD_SQUARE;
      default: return mode_e'(raw);
    endcase
  endfunction

  function automatic logic edge_restart(input mode_e m);
    return m inside {MD_ONE_SHOT, MD_RATE, MD_SQUARE, MD_HW_STROBE};
  endfunction

  function automatic logic level_gated(input mode_e m);
    return m inside {MD_TC_RISE, MD_SW_STROBE};
  endfunction

  function automatic logic init_level(input mode_e m);
    return m inside {MD_ONE_SHOT, MD_SQUARE};
  endfunction

endpackage

// File: rtl/ictr_gate_ctl.sv
module ictr_gate_ctl
  import ictr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  gate_i,
  input  logic  tick_i,
  input  mode_e mode_i,
  output logic  restart_o,
  output logic  step_o
);

  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  assign restart_o = gate_i && !gate_q && edge_restart(mode_i);
  assign step_o    = tick_i && (gate_i || !level_gated(mode_i));

endmodule

// File: rtl/ictr_down_cnt.sv
module ictr_down_cnt
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int EXT_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             restart_i,
  input  logic             step_i,
  input  mode_e            mode_i,
  output logic [EXT_W-1:0] cnt_o,
  output logic [EXT_W-1:0] per_o
);

  localparam logic [EXT_W-1:0] FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [EXT_W-1:0] ONE  = EXT_W'(1);
  localparam logic [EXT_W-1:0] TWO  = EXT_W'(2);

  logic [EXT_W-1:0] cnt_q, per_q, load_per, sq_wrap, cnt_d;
  logic [EXT_W:0]   sq_sum;

  assign load_per = (reload_i == '0) ? FULL : {1'b0, reload_i};
  assign sq_sum   = {1'b0, cnt_q} + {1'b0, per_q} - (EXT_W+1)'(2);
  assign sq_wrap  = (sq_sum == '0) ? per_q : sq_sum[EXT_W-1:0];

  always_comb begin
    cnt_d = cnt_q;
    if (step_i) begin
      case (mode_i)
        MD_RATE:   cnt_d = (cnt_q == ONE) ? per_q : cnt_q - ONE;
        MD_SQUARE: cnt_d = (cnt_q > TWO) ? cnt_q - TWO : sq_wrap;
        default:   cnt_d = cnt_q - ONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= FULL;
      cnt_q <= FULL;
    end else if (load_i) begin
      per_q <= load_per;
      cnt_q <= load_per;
    end else if (restart_i) begin
      cnt_q <= per_q;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;

  AST_PERIODIC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {MD_RATE, MD_SQUARE}) |-> (cnt_q != '0 && cnt_q <= per_q)); // R6

endmodule

// File: rtl/ictr_out_gen.sv
module ictr_out_gen
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int EXT_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  mode_e            load_mode_i,
  input  logic             restart_i,
  input  logic             step_i,
  input  mode_e            mode_i,
  input  logic [EXT_W-1:0] cnt_i,
  input  logic [EXT_W-1:0] per_i,
  output logic             out_o
);

  localparam logic [EXT_W-1:0] ONE = EXT_W'(1);
  localparam logic [EXT_W-1:0] TWO = EXT_W'(2);

  logic done_q, out_q, done_d, out_d, tc;

  // first arrival at terminal count since the last start
  assign tc = (cnt_i == ONE) && !done_q;

  always_comb begin
    done_d = done_q;
    out_d  = out_q;
    if (step_i) begin
      case (mode_i)
        MD_TC_RISE:  if (tc) begin done_d = 1'b1; out_d = 1'b1; end
        MD_ONE_SHOT: if (tc) begin done_d = 1'b1; out_d = 1'b0; end
        MD_RATE:     out_d = (cnt_i == ONE);
        MD_SQUARE:   if (cnt_i <= TWO && per_i != ONE) out_d = !out_q;
        default: begin
          out_d = tc;
          if (tc) done_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      out_q  <= 1'b0;
    end else if (load_i) begin
      done_q <= 1'b0;
      out_q  <= init_level(load_mode_i);
    end else if (restart_i) begin
      done_q <= 1'b0;
      out_q  <= init_level(mode_i);
    end else begin
      done_q <= done_d;
      out_q  <= out_d;
    end
  end

  assign out_o = out_q;

  AST_TC_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_TC_RISE && out_q && !load_i) |=> out_q); // R3

  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {MD_SW_STROBE, MD_HW_STROBE} && out_q && step_i && !load_i && !restart_i)
      |=> !out_q); // R7

  AST_RATE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_RATE && out_q) |-> (cnt_i == per_i)); // R5

endmodule

// File: rtl/interval_chan.sv
module interval_chan
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int EXT_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [2:0]       mode_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);

  mode_e            mode_q, load_mode;
  logic             restart, step;
  logic [EXT_W-1:0] cnt, per;

  assign load_mode = norm_mode(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= MD_TC_RISE;
    else if (load_i) mode_q <= load_mode;
  end

  ictr_gate_ctl u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gate_i    (gate_i),
    .tick_i    (tick_i),
    .mode_i    (mode_q),
    .restart_o (restart),
    .step_o    (step)
  );

  ictr_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .reload_i  (reload_i),
    .restart_i (restart),
    .step_i    (step),
    .mode_i    (mode_q),
    .cnt_o     (cnt),
    .per_o     (per)
  );

  ictr_out_gen #(.CNT_W(CNT_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_mode_i (load_mode),
    .restart_i   (restart),
    .step_i      (step),
    .mode_i      (mode_q),
    .cnt_i       (cnt),
    .per_i       (per),
    .out_o       (out_o)
  );

  assign count_o = cnt[CNT_W-1:0];

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_o == $past(reload_i))); // R2

  AST_LOAD_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (out_o == init_level(norm_mode($past(mode_i))))); // R2

  AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_gated(mode_q) && !gate_i && !load_i) |=> ($stable(count_o) && $stable(out_o))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && (!gate_i || !edge_restart(mode_q))) |=> $stable(count_o)); // R8

endmodule

// File: tb/interval_chan_bench.sv
module interval_chan_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        gate_i = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] reload_i = '0;
  logic [2:0]  mode_i = '0;
  logic        out_o;
  logic [15:0] count_o;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  string cur_req = "R1";

  always #4 clk_i = ~clk_i;

  interval_chan u_interval_chan (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .gate_i(gate_i),
    .load_i(load_i), .reload_i(reload_i), .mode_i(mode_i),
    .out_o(out_o), .count_o(count_o)
  );

  // behavioural model: elapsed ticks as an integer
  int     m_mode;
  longint m_per, m_e;
  bit     m_gprev;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_per = 65536; m_e = 0; m_gprev = 0;
    end else begin
      if (load_i) begin
        m_mode = (mode_i == 6) ? 2 : (mode_i == 7) ? 3 : int'(mode_i);
        m_per  = (reload_i == 0) ? 65536 : longint'(reload_i);
        m_e    = 0;
      end else if (gate_i && !m_gprev && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
        m_e = 0;
      end else if (tick_i && (gate_i || !(m_mode == 0 || m_mode == 4))) begin
        m_e++;
      end
      m_gprev = gate_i;
    end
  end

  function automatic longint exp_count();
    case (m_mode)
      2:       return (m_per - (m_e % m_per)) & 16'hFFFF;
      3:       return (m_per - ((2 * m_e) % m_per)) & 16'hFFFF;
      default: return (m_per - m_e) & 16'hFFFF;
    endcase
  endfunction

  function automatic bit exp_out();
    case (m_mode)
      0:       return m_e >= m_per;
      1:       return m_e < m_per;
      2:       return (m_e != 0) && (m_e % m_per == 0);
      3:       return (m_per == 1) ? 1'b1 : ((m_e % m_per) < ((m_per + 1) / 2));
      default: return m_e == m_per;
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(cur_req, longint'(count_o), exp_count(), "count_o");
      check(cur_req, longint'(out_o), longint'(exp_out()), "out_o");
    end
  end

  task automatic do_load(input int md, input int val);
    @(negedge clk_i);
    load_i = 1'b1; mode_i = 3'(md); reload_i = 16'(val);
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  // pattern 0: tick every cycle, 1: every third cycle, 2: none
  task automatic run(input int n, input int pat);
    for (int i = 0; i < n; i++) begin
      tick_i = (pat == 0) ? 1'b1 : (pat == 1) ? (i % 3 == 0) : 1'b0;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
  endtask

  task automatic gate_pulse();
    gate_i = 1'b0; @(negedge clk_i);
    gate_i = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", count_o, 0, "reset count_o");
    check("R1", out_o, 0, "reset out_o");
    run(4, 0);

    cur_req = "R3"; gate_i = 1'b1;
    do_load(0, 5); run(9, 0); run(8, 1);
    cur_req = "R11"; do_load(0, 3); run(8, 0);
    cur_req = "R9"; do_load(4, 4); gate_i = 1'b0; run(6, 0);
    gate_i = 1'b1; run(3, 0); gate_i = 1'b0; run(4, 0); gate_i = 1'b1; run(6, 0);
    cur_req = "R9"; do_load(0, 6); run(2, 0); gate_i = 1'b0; run(5, 0); gate_i = 1'b1; run(7, 0);

    cur_req = "R4"; do_load(1, 4); run(3, 0);
    cur_req = "R8"; gate_pulse(); run(7, 0); run(4, 1);
    cur_req = "R5"; do_load(2, 3); run(10, 0); run(9, 1);
    do_load(2, 1); run(4, 0);
    cur_req = "R8"; do_load(2, 5); run(3, 0); gate_pulse(); run(7, 0);
    cur_req = "R6"; do_load(3, 5); run(13, 0); do_load(3, 4); run(10, 1);
    do_load(3, 1); run(3, 0); do_load(3, 2); run(5, 0);
    cur_req = "R8"; do_load(3, 7); run(4, 0); gate_pulse(); run(9, 0);
    cur_req = "R7"; do_load(4, 3); run(6, 0); run(6, 1);
    do_load(5, 2); run(4, 0); gate_pulse(); run(5, 0);
    cur_req = "R10"; do_load(6, 3); run(8, 0); do_load(7, 5); run(12, 0);

    cur_req = "R2"; do_load(2, 0); run(4, 0);
    do_load(1, 0); run(3, 0);
    // load with a tick and a gate edge in the same cycle
    gate_i = 1'b0; @(negedge clk_i);
    tick_i = 1'b1; gate_i = 1'b1; load_i = 1'b1; mode_i = 3'd3; reload_i = 16'd6;
    @(negedge clk_i);
    load_i = 1'b0; tick_i = 1'b0;
    check("R2", count_o, 6, "load priority count_o");
    run(5, 0);
    cur_req = "R11"; do_load(5, 2); run(5, 0);

    run(2, 2);
    finish_run();
  end

endmodule